// File: doc/BRIEF.md
# Pause-Width Bit Transmitter

This block sends a short reader-to-tag command frame over a single carrier-enable line. Each bit opens with a fixed interval with the carrier off. The carrier then comes back on, and the total length of the bit tells the receiver its value. Before a bit is encoded, the block XORs it with one bit from an external keystream. Once per bit it pulses a request so that the keystream source moves on to the next bit. After the last bit, one more carrier-off interval marks the end of the frame.

All timing is counted in pulses of a tick enable. In the intended system the tick is the system clock divided by 32, about 0.67 µs. When a frame ends, the block restarts a free-running tick counter from zero. Logic that waits for the tag's reply can measure its delay from that counter. The keystream generator and the analog front end are outside this block.

Top module: `pause_width_tx`

## Requirements
- R1: After reset, `carrier_on` is 1, `done` and `ks_adv` are 0, and `since_end` is 0.
- R2: Each bit starts in the cycle after its start condition. It begins with the carrier off for PAUSE_TICKS (30) tick pulses.
- R3: A transmitted symbol 1 lasts ONE_TICKS (150) ticks in total, pause included, so the carrier is on for 120 ticks. A symbol 0 lasts ZERO_TICKS (90) ticks, so the carrier is on for 60 ticks.
- R4: Data bits are sent least significant first: `tx_data[0]` goes first.
- R5: The symbol sent for a bit is the data bit XOR the `ks_bit` value present on the last tick of that bit's pause.
- R6: `ks_adv` pulses for exactly one clock per bit, in the first carrier-on cycle of that bit. It never pulses in any other cycle.
- R7: After the last bit, the carrier is off for one further PAUSE_TICKS interval. It then stays on until the next frame.
- R8: `done` is high for exactly one clock, the cycle in which the carrier returns after the end pause.
- R9: `since_end` is 0 in the `done` cycle. After that it increments once per `tick_en` pulse and saturates at its maximum.
- R10: A `start` pulse that arrives while a frame is in progress is ignored. The frame in progress, and the number of keystream advances, are unchanged.
- R11: A `tx_bits` value of 0 sends only the end pause, with no keystream advance. A value above MAX_BITS (16) is treated as 16.
- R12: While `tick_en` is low, no timing interval advances and the carrier level holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-clock timing tick |
| start | input | 1 | Frame launch strobe, taken only when idle |
| tx_data | input | MAX_BITS | Frame bits, bit 0 sent first |
| tx_bits | input | CNT_W | Number of bits to send (0 to MAX_BITS) |
| ks_bit | input | 1 | Current keystream bit |
| ks_adv | output | 1 | Request to advance the keystream by one step |
| carrier_on | output | 1 | Carrier enable, 0 during pauses |
| done | output | 1 | One-clock pulse at frame end |
| since_end | output | TIME_W | Ticks since the last frame ended |

## Verification
With `tick_en` held high, the carrier falls in the clock after `start` is sampled. Each interval then lasts exactly its tick count in clocks, so the monitor measures every carrier run in clocks at the falling edge. It compares each run with the pause/mark length that the driver queued from the data, the keystream pattern and the bit count.

`done` and the restarted `since_end` are sampled in the same falling-edge window in which the carrier is seen to rise after the end pause. One clock later, the bench checks that `done` has dropped and `since_end` reads 1.

The bench counts keystream advances in the clocks where `ks_adv` is seen high, and compares that count with the bit count once the frame has ended. In the gated case, the driver adds the number of clocks with the tick held low to the expected first pause.

// File: rtl/pwtx_pkg.sv
package pwtx_pkg;

    typedef enum logic [1:0] {
        PW_IDLE  = 2'd0,
        PW_PAUSE = 2'd1,
        PW_MARK  = 2'd2,
        PW_TAIL  = 2'd3
    } pw_state_e;

    typedef struct packed {
        pw_state_e st;
        logic      sym;
        logic      adv;
        logic      done;
    } pw_ctl_s;

endpackage

// File: rtl/pwtx_counter.sv
module pwtx_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (inc && cnt_q != TOP) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign value = cnt_q;
endmodule

// File: rtl/pwtx_shifter.sv
module pwtx_shifter #(
    parameter int MAX_BITS = 16,
    parameter int CNT_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                shift,
    input  logic [MAX_BITS-1:0] data_in,
    input  logic [CNT_W-1:0]    count_in,
    output logic                lsb,
    output logic                last
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_BITS);

    logic [MAX_BITS-1:0] data_d, data_q;
    logic [CNT_W-1:0]    left_d, left_q;

    always_comb begin
        data_d = data_q;
        left_d = left_q;
        if (load) begin
            data_d = data_in;
            left_d = (count_in > CAP) ? CAP : count_in;
        end else if (shift) begin
            data_d = data_q >> 1;
            left_d = (left_q != '0) ? left_q - 1'b1 : left_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            left_q <= '0;
        end else begin
            data_q <= data_d;
            left_q <= left_d;
        end
    end

    assign lsb  = data_q[0];
    assign last = (left_q <= CNT_W'(1));
endmodule

// File: rtl/pause_width_tx.sv
module pause_width_tx
    import pwtx_pkg::*;
#(
    parameter int MAX_BITS    = 16,
    parameter int CNT_W       = $clog2(MAX_BITS + 1),
    parameter int TIME_W      = 16,
    parameter int PAUSE_TICKS = 30,
    parameter int ONE_TICKS   = 150,
    parameter int ZERO_TICKS  = 90
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en,
    input  logic                start,
    input  logic [MAX_BITS-1:0] tx_data,
    input  logic [CNT_W-1:0]    tx_bits,
    input  logic                ks_bit,
    output logic                ks_adv,
    output logic                carrier_on,
    output logic                done,
    output logic [TIME_W-1:0]   since_end
);
    localparam int MARK_ONE  = ONE_TICKS - PAUSE_TICKS;
    localparam int MARK_ZERO = ZERO_TICKS - PAUSE_TICKS;
    localparam int PH_W      = $clog2(ONE_TICKS + 1);
    localparam logic [PH_W-1:0] PAUSE_LAST = PH_W'(PAUSE_TICKS - 1);
    localparam logic [PH_W-1:0] ONE_LAST   = PH_W'(MARK_ONE - 1);
    localparam logic [PH_W-1:0] ZERO_LAST  = PH_W'(MARK_ZERO - 1);

    pw_ctl_s ctl_d, ctl_q;

    logic [PH_W-1:0] phase;
    logic            launch;
    logic            phase_end;
    logic            frame_end;
    logic            do_shift;
    logic            cur_lsb;
    logic            last_bit;
    logic            busy_w;

    assign busy_w = (ctl_q.st != PW_IDLE);
    assign launch = start && !busy_w;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.adv  = 1'b0;
        ctl_d.done = 1'b0;
        phase_end  = 1'b0;
        frame_end  = 1'b0;
        do_shift   = 1'b0;
        unique case (ctl_q.st)
            PW_IDLE: begin
                if (launch) begin
                    ctl_d.st = (tx_bits == '0) ? PW_TAIL : PW_PAUSE;
                end
            end
            PW_PAUSE: begin
                if (tick_en && phase == PAUSE_LAST) begin
                    phase_end = 1'b1;
                    ctl_d.sym = cur_lsb ^ ks_bit;
                    ctl_d.adv = 1'b1;
                    ctl_d.st  = PW_MARK;
                end
            end
            PW_MARK: begin
                if (tick_en && phase == (ctl_q.sym ? ONE_LAST : ZERO_LAST)) begin
                    phase_end = 1'b1;
                    do_shift  = 1'b1;
                    ctl_d.st  = last_bit ? PW_TAIL : PW_PAUSE;
                end
            end
            PW_TAIL: begin
                if (tick_en && phase == PAUSE_LAST) begin
                    phase_end  = 1'b1;
                    frame_end  = 1'b1;
                    ctl_d.done = 1'b1;
                    ctl_d.st   = PW_IDLE;
                end
            end
            default: ctl_d.st = PW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: PW_IDLE, sym: 1'b0, adv: 1'b0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    pwtx_counter #(.W(PH_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (launch | phase_end),
        .inc   (tick_en & busy_w),
        .value (phase)
    );

    pwtx_counter #(.W(TIME_W)) u_since (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (frame_end),
        .inc   (tick_en),
        .value (since_end)
    );

    pwtx_shifter #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .shift    (do_shift),
        .data_in  (tx_data),
        .count_in (tx_bits),
        .lsb      (cur_lsb),
        .last     (last_bit)
    );

    assign ks_adv     = ctl_q.adv;
    assign done       = ctl_q.done;
    assign carrier_on = !(ctl_q.st == PW_PAUSE || ctl_q.st == PW_TAIL);
endmodule

// File: rtl/pwtx_checker.sv
module pwtx_checker #(
    parameter int TIME_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              start,
    input logic              busy,
    input logic              ks_adv,
    input logic              carrier_on,
    input logic              done,
    input logic [TIME_W-1:0] since_end
);
    // R6
    adv_in_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ks_adv |-> carrier_on && busy);

    // R6
    adv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ks_adv |=> !ks_adv);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> carrier_on && !busy);

    // R9
    since_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> since_end == '0);

    // R2
    launch_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !carrier_on);

    // R12
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick_en) |=> $stable(carrier_on));

    // R7
    idle_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> carrier_on);
endmodule

bind pause_width_tx pwtx_checker #(.TIME_W(TIME_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .start      (start),
    .busy       (busy_w),
    .ks_adv     (ks_adv),
    .carrier_on (carrier_on),
    .done       (done),
    .since_end  (since_end)
);

// File: tb/pause_width_tx_tb.sv
module pause_width_tx_tb;
    localparam int MAX_BITS = 16;
    localparam int CNT_W    = 5;
    localparam int TIME_W   = 16;
    localparam int PAUSE    = 30;
    localparam int MARK1    = 120;
    localparam int MARK0    = 60;
    localparam logic [63:0] KS_PAT = 64'h9E37_79B9_7F4A_7C15;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                tick_en = 1'b1;
    logic                start = 1'b0;
    logic [MAX_BITS-1:0] tx_data = '0;
    logic [CNT_W-1:0]    tx_bits = '0;
    logic                ks_bit;
    logic                ks_adv;
    logic                carrier_on;
    logic                done;
    logic [TIME_W-1:0]   since_end;

    logic [15:0] ks_idx = '0;
    int checks = 0;
    int failures = 0;
    int model_idx = 0;

    int    exp_len[$];
    int    exp_lvl[$];
    string exp_req[$];

    always #5 clk = ~clk;

    assign ks_bit = KS_PAT[ks_idx[5:0]];

    always @(posedge clk) begin
        if (ks_adv) ks_idx <= ks_idx + 16'd1;
    end

    pause_width_tx #(
        .MAX_BITS(MAX_BITS), .CNT_W(CNT_W), .TIME_W(TIME_W),
        .PAUSE_TICKS(30), .ONE_TICKS(150), .ZERO_TICKS(90)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start(start),
        .tx_data(tx_data), .tx_bits(tx_bits), .ks_bit(ks_bit),
        .ks_adv(ks_adv), .carrier_on(carrier_on), .done(done),
        .since_end(since_end)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: measures carrier runs and compares them with the queue
    logic prev_lvl = 1'b1;
    int   run = 0;
    bit   in_frame = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (carrier_on != prev_lvl) begin
                if (prev_lvl == 1'b0 || in_frame) begin
                    if (exp_len.size() == 0) begin
                        chk(1'b0, "R7", "unexpected carrier run", run, 0);
                    end else begin
                        automatic int    el = exp_len.pop_front();
                        automatic int    ev = exp_lvl.pop_front();
                        automatic string er = exp_req.pop_front();
                        chk(ev == int'(prev_lvl), er, "run level", int'(prev_lvl), ev);
                        chk(run == el, er, "run length", run, el);
                    end
                end
                if (prev_lvl == 1'b0) in_frame = 1'b1;
                prev_lvl = carrier_on;
                run = 1;
            end else begin
                run++;
            end
            if (done) in_frame = 1'b0;
            if (ks_adv) chk(carrier_on == 1'b1, "R6", "advance outside mark", int'(carrier_on), 1);
        end
    end

    task automatic push(input int lvl, input int len, input string req);
        exp_lvl.push_back(lvl);
        exp_len.push_back(len);
        exp_req.push_back(req);
    endtask

    task automatic queue_frame(input logic [15:0] d, input int n, input int gate);
        for (int i = 0; i < n; i++) begin
            automatic logic sym = d[i] ^ KS_PAT[(model_idx + i) % 64];
            push(0, PAUSE + ((i == 0) ? gate : 0), "R2");
            push(1, sym ? MARK1 : MARK0, sym ? "R3 R4 R5 one" : "R3 R4 R5 zero");
        end
        push(0, PAUSE + ((n == 0) ? gate : 0), "R7");
    endtask

    task automatic launch(input logic [15:0] d, input int cnt, input int n, input int gate);
        @(negedge clk);
        queue_frame(d, n, gate);
        tx_data = d;
        tx_bits = CNT_W'(cnt);
        start   = 1'b1;
        tick_en = 1'b0;
        @(negedge clk);
        start = 1'b0;
        repeat (gate) @(negedge clk);
        tick_en = 1'b1;
    endtask

    task automatic finish_frame(input int n, input string req);
        while (!done) @(negedge clk);
        chk(carrier_on == 1'b1, "R8", "carrier at done", int'(carrier_on), 1);
        chk(since_end == 0, "R9", "since_end at done", int'(since_end), 0);
        chk(int'(ks_idx) == model_idx + n, req, "keystream advances", int'(ks_idx) - model_idx, n);
        model_idx = int'(ks_idx);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done width", int'(done), 0);
        chk(since_end == 1, "R9", "since_end after one tick", int'(since_end), 1);
        chk(exp_len.size() == 0, "R7", "runs left in queue", exp_len.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(carrier_on == 1'b1, "R1", "reset carrier", int'(carrier_on), 1);
        chk(done == 1'b0, "R1", "reset done", int'(done), 0);
        chk(ks_adv == 1'b0, "R1", "reset ks_adv", int'(ks_adv), 0);
        chk(since_end == 0, "R1", "reset since_end", int'(since_end), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(since_end == 5, "R9", "free count", int'(since_end), 5);

        launch(16'h0001, 1, 1, 0);       finish_frame(1, "R6");
        launch(16'h00F0, 8, 8, 0);       finish_frame(8, "R6");
        launch(16'hFFFF, 16, 16, 0);     finish_frame(16, "R6");
        launch(16'h1234, 0, 0, 0);       finish_frame(0, "R11");   // R11 zero count
        launch(16'hBEEF, 20, 16, 0);     finish_frame(16, "R11");  // R11 clamp
        launch(16'h5A3C, 3, 3, 17);      finish_frame(3, "R12");   // R12 gated tick

        // R10: start while busy is ignored
        launch(16'h00A5, 8, 8, 0);
        repeat (200) @(negedge clk);
        tx_data = 16'hFFFF;
        tx_bits = CNT_W'(16);
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_frame(8, "R10");

        repeat (20) @(negedge clk);
        chk(carrier_on == 1'b1, "R7", "carrier stays on idle", int'(carrier_on), 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule